// File: doc/BRIEF.md
# Scan Chain Failing Element Locator

This block finds the failing storage element of a scan chain from two preload tests. The chain is preloaded with a checkerboard pattern and then with its complement. Each time, the whole chain is shifted out and the serial bits enter this block one per valid cycle. The block compares every bit against the value the preload should have left in that element. It records a mismatch mask for each pattern and keeps, for each pattern, the mismatching element nearest the scan output.

When the second pass ends, the block reports a fail flag and the failing element. The failing element is the smaller of the two per-pattern nearest-mismatch indices, with element 1 sitting next to the scan output. Combining the two complementary passes locates a stuck element exactly. A stuck element corrupts every bit that passes through it, so the element nearest the output that either pass flags is the faulty one. A new `start_i` pulse discards all earlier results and arms the block for a new pair of passes.

Top module: `scan_fail_locator`

## Requirements
- R1: After reset, and in the cycle after `start_i` is sampled high, `done_o` and `fail_o` are 0, `fail_idx_o` is 0 and both masks are 0.
- R2: The k-th accepted bit of a pass is element k, and element 1 is nearest the scan output. With `pat_sel_i`=0 (checkerboard), an odd element is expected to read 1 and an even element 0. With `pat_sel_i`=1 (reverse checkerboard), an odd element is expected to read 0 and an even element 1.
- R3: Bit k-1 of `mask_ck_o` (bits received with `pat_sel_i`=0) or of `mask_rc_o` (bits received with `pat_sel_i`=1) is 1 exactly when element k mismatched in that pass.
- R4: `fail_idx_o` equals the lowest element index that mismatched in either pass, so it is the smaller of the two per-pass nearest mismatches.
- R5: When no bit mismatched in either pass, `fail_o` is 0 and `fail_idx_o` is 0. Otherwise `fail_o` is 1.
- R6: `done_o` is high for exactly one cycle: the cycle after the clock edge that samples the N-th valid bit of the second pass. The results then hold until the next start.
- R7: Bits are ignored when `bit_vld_i` is low, before the first start, or after a run has completed. A bit presented in the same cycle as `start_i` is also ignored.
- R8: With N=8 and element 4 stuck at 0, the checkerboard pass first mismatches at element 5, the reverse pass at element 4, and `fail_idx_o` is 4.
- R9: A start issued in the middle of a run abandons it, clears all partial results and restarts at element 1 of the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears results and arms a new pair of passes |
| pat_sel_i | input | 1 | Preload pattern of the current bit: 0 checkerboard, 1 reverse |
| bit_vld_i | input | 1 | Scan-out bit is present this cycle |
| bit_dat_i | input | 1 | Scan-out bit value |
| done_o | output | 1 | One-cycle pulse after the last bit of the second pass |
| fail_o | output | 1 | At least one mismatch was seen |
| fail_idx_o | output | $clog2(N_ELEM+1) | Failing element nearest the output, 0 if none |
| mask_ck_o | output | N_ELEM | Mismatch mask of the checkerboard pass |
| mask_rc_o | output | N_ELEM | Mismatch mask of the reverse checkerboard pass |

## Verification
The assertions assume that `pat_sel_i` stays constant for the N bits of a pass and takes the other value in the second pass, so that each mask is written by one pass only. The stimulus changes the selector only between passes. It sweeps every stuck position and value in both pass orders and inserts idle cycles inside passes. Invalid, early, late and start-coincident bits are driven deliberately to show that they leave the results untouched.

// File: rtl/scan_loc_pkg.sv
package scan_loc_pkg;
  typedef enum logic {
    PAT_CHECKER = 1'b0,
    PAT_REVERSE = 1'b1
  } pat_e;

  // Checkerboard leaves 1 in odd elements (element 1 nearest the output).
  function automatic logic expected_bit(pat_e p, logic elem_odd);
    return (p == PAT_CHECKER) ? elem_odd : ~elem_odd;
  endfunction
endpackage

// File: rtl/scan_loc_seq.sv
module scan_loc_seq #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             vld_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] elem_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_ELEM = IDX_W'(N);

  logic             armed_q;
  logic             pass_q;
  logic [IDX_W-1:0] elem_q;

  assign accept_o = vld_i && armed_q && !start_i;
  assign elem_o   = elem_q;
  assign last_o   = accept_o && pass_q && (elem_q == LAST_ELEM);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pass_q  <= 1'b0;
      elem_q  <= IDX_W'(1);
    end else if (start_i) begin
      armed_q <= 1'b1;
      pass_q  <= 1'b0;
      elem_q  <= IDX_W'(1);
    end else if (accept_o) begin
      if (elem_q == LAST_ELEM) begin
        elem_q <= IDX_W'(1);
        pass_q <= ~pass_q;
        if (pass_q) armed_q <= 1'b0;
      end else begin
        elem_q <= elem_q + 1'b1;
      end
    end
  end

  AST_ELEM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (elem_q >= IDX_W'(1)) && (elem_q <= LAST_ELEM)); // R2
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    last_o |=> !armed_q); // R7
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (armed_q && !pass_q && elem_q == IDX_W'(1))); // R9
endmodule

// File: rtl/scan_loc_cmp.sv
module scan_loc_cmp
  import scan_loc_pkg::*;
#(
  parameter int   N     = 8,
  parameter int   IDX_W = 4,
  parameter pat_e PAT   = PAT_CHECKER
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             hit_i,
  input  pat_e             sel_i,
  input  logic [IDX_W-1:0] elem_i,
  input  logic             dat_i,
  output logic [N-1:0]     mask_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0]     mask_q;
  logic [IDX_W-1:0] idx_q;
  logic             take, mism;

  assign take   = hit_i && (sel_i == PAT);
  assign mism   = dat_i != expected_bit(PAT, elem_i[0]);
  assign mask_o = mask_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      mask_q <= '0;
      idx_q  <= '0;
    end else if (take && mism) begin
      for (int i = 0; i < N; i++)
        if (elem_i == IDX_W'(i + 1)) mask_q[i] <= 1'b1;
      if (idx_q == '0) idx_q <= elem_i;
    end
  end

  // Independent priority search over the stored mask for the checks below.
  logic [IDX_W-1:0] chk_low;
  always_comb begin
    chk_low = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mask_q[i]) chk_low = IDX_W'(i + 1);
  end

  AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (rst)
    idx_q == chk_low); // R4
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (idx_q != '0 && !clr_i) |=> idx_q == $past(idx_q)); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (mask_q == '0 && idx_q == '0)); // R1
endmodule

// File: rtl/scan_fail_locator.sv
module scan_fail_locator
  import scan_loc_pkg::*;
#(
  parameter int N_ELEM = 8,
  parameter int IDX_W  = $clog2(N_ELEM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              pat_sel_i,
  input  logic              bit_vld_i,
  input  logic              bit_dat_i,
  output logic              done_o,
  output logic              fail_o,
  output logic [IDX_W-1:0]  fail_idx_o,
  output logic [N_ELEM-1:0] mask_ck_o,
  output logic [N_ELEM-1:0] mask_rc_o
);
  localparam int N_PAT = 2;

  logic             accept, last;
  logic [IDX_W-1:0] elem;
  logic             done_q;
  logic [N_ELEM-1:0] mask_arr [N_PAT];
  logic [IDX_W-1:0]  idx_arr  [N_PAT];

  scan_loc_seq #(.N(N_ELEM), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .vld_i    (bit_vld_i),
    .accept_o (accept),
    .elem_o   (elem),
    .last_o   (last)
  );

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    scan_loc_cmp #(.N(N_ELEM), .IDX_W(IDX_W), .PAT(pat_e'(p))) u_cmp (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (start_i),
      .hit_i  (accept),
      .sel_i  (pat_e'(pat_sel_i)),
      .elem_i (elem),
      .dat_i  (bit_dat_i),
      .mask_o (mask_arr[p]),
      .idx_o  (idx_arr[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || start_i) done_q <= 1'b0;
    else                done_q <= last;
  end

  always_comb begin
    if (idx_arr[0] == '0)      fail_idx_o = idx_arr[1];
    else if (idx_arr[1] == '0) fail_idx_o = idx_arr[0];
    else if (idx_arr[0] < idx_arr[1]) fail_idx_o = idx_arr[0];
    else                       fail_idx_o = idx_arr[1];
  end

  assign fail_o    = (idx_arr[0] != '0) || (idx_arr[1] != '0);
  assign done_o    = done_q;
  assign mask_ck_o = mask_arr[0];
  assign mask_rc_o = mask_arr[1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_CLEAN_NO_FAIL: assert property (@(posedge clk) disable iff (rst)
    !fail_o |-> (mask_ck_o == '0 && mask_rc_o == '0 && fail_idx_o == '0)); // R5
  AST_DONE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> $stable(fail_idx_o) && $stable(mask_ck_o) && $stable(mask_rc_o)); // R6
endmodule

// File: tb/scan_fail_locator_tb.sv
module scan_fail_locator_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N + 1);

  logic clk = 0, rst = 1, start = 0, sel = 0, vld = 0, dat = 0;
  logic done, fail;
  logic [IW-1:0] fidx;
  logic [N-1:0] mck, mrc;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  scan_fail_locator #(.N_ELEM(N)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .pat_sel_i(sel),
    .bit_vld_i(vld), .bit_dat_i(dat), .done_o(done), .fail_o(fail),
    .fail_idx_o(fidx), .mask_ck_o(mck), .mask_rc_o(mrc)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected content of element k (bit k-1) for a pattern: R2.
  function automatic logic [N-1:0] pat_vec(input logic s);
    logic [N-1:0] v;
    for (int k = 1; k <= N; k++) v[k-1] = s ? ~k[0] : k[0];
    return v;
  endfunction

  function automatic logic [N-1:0] stuck_obs(input logic s, input int f, input logic val);
    logic [N-1:0] v = pat_vec(s);
    for (int k = f; k <= N; k++) v[k-1] = val;
    return v;
  endfunction

  task automatic do_start(input logic with_bit);
    @(negedge clk);
    start = 1; vld = with_bit; dat = ~dat;
    @(negedge clk);
    start = 0; vld = 0;
  endtask

  task automatic send_pass(input logic s, input logic [N-1:0] obs, input logic gaps);
    for (int k = 1; k <= N; k++) begin
      if (gaps && (k % 3 == 1)) begin
        @(negedge clk); vld = 0; dat = ~obs[k-1];
      end
      @(negedge clk);
      sel = s; vld = 1; dat = obs[k-1];
    end
  endtask

  task automatic run_pair(input logic s0, input logic [N-1:0] o0, input logic [N-1:0] o1,
                          input logic gaps, input logic start_bit, input string tag);
    logic [N-1:0] m0, m1, eck, erc;
    int eidx;
    do_start(start_bit);
    send_pass(s0, o0, gaps);
    send_pass(~s0, o1, gaps);
    @(negedge clk);
    vld = 0;
    m0 = o0 ^ pat_vec(s0);
    m1 = o1 ^ pat_vec(~s0);
    eck = s0 ? m1 : m0;
    erc = s0 ? m0 : m1;
    eidx = 0;
    for (int k = N; k >= 1; k--) if (eck[k-1] || erc[k-1]) eidx = k;
    chk({"R6 done pulse ", tag}, int'(done), 1);
    chk({"R2,R3 ck mask ", tag}, int'(mck), int'(eck));
    chk({"R2,R3 rc mask ", tag}, int'(mrc), int'(erc));
    chk({"R4 fail index ", tag}, int'(fidx), eidx);
    chk({"R5 fail flag ", tag}, int'(fail), int'(eidx != 0));
    @(negedge clk);
    chk({"R6 done low ", tag}, int'(done), 0);
    chk({"R6 index held ", tag}, int'(fidx), eidx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [N-1:0] sck, src;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset fail", int'(fail), 0);
    chk("R1 reset idx", int'(fidx), 0);
    chk("R1 reset masks", int'(mck | mrc), 0);

    // R7: bits before any start are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); vld = 1; dat = 1'b1; sel = k[0];
    end
    @(negedge clk); vld = 0;
    chk("R7 pre-start ignored", int'(mck | mrc) + int'(fidx), 0);

    // R5: clean pair, both orders
    run_pair(1'b0, pat_vec(1'b0), pat_vec(1'b1), 1'b0, 1'b0, "clean");
    run_pair(1'b1, pat_vec(1'b1), pat_vec(1'b0), 1'b1, 1'b0, "clean rev");

    // R8: element 4 stuck at 0 in an 8-element chain
    run_pair(1'b0, stuck_obs(1'b0, 4, 1'b0), stuck_obs(1'b1, 4, 1'b0), 1'b0, 1'b0, "R8");
    chk("R8 ck nearest is 5", int'(mck[3:0] == 4'b0000 && mck[4]), 1);
    chk("R8 rc nearest is 4", int'(mrc[2:0] == 3'b000 && mrc[3]), 1);
    chk("R8 result 4", int'(fidx), 4);

    // R7: bits after completion are ignored
    for (int k = 0; k < N + 2; k++) begin
      @(negedge clk); vld = 1; dat = ~dat; sel = k[0];
      chk("R7 no done after run", int'(done), 0);
    end
    @(negedge clk); vld = 0;
    chk("R7 late bits idx", int'(fidx), 4);
    chk("R7 late bits ck mask", int'(mck), int'(stuck_obs(1'b0, 4, 1'b0) ^ pat_vec(1'b0)));

    // R7: a bit in the start cycle is ignored; R1: start clears
    run_pair(1'b0, pat_vec(1'b0), pat_vec(1'b1), 1'b1, 1'b1, "R7 start-bit");

    // R9: abandon a run midway
    do_start(1'b0);
    chk("R1 start clears idx", int'(fidx), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); vld = 1; sel = 0; dat = ~pat_vec(1'b0)[k];
    end
    @(negedge clk); vld = 0;
    chk("R9 partial recorded", int'(fidx), 1);
    run_pair(1'b0, pat_vec(1'b0), pat_vec(1'b1), 1'b0, 1'b0, "R9 restart");

    // R2: single flipped bits at every element, each pattern
    for (int e = 1; e <= N; e++) begin
      sck = pat_vec(1'b0); sck[e-1] = ~sck[e-1];
      run_pair(1'b0, sck, pat_vec(1'b1), e[0], 1'b0, "R2 flip ck");
      src = pat_vec(1'b1); src[e-1] = ~src[e-1];
      run_pair(1'b1, src, pat_vec(1'b0), 1'b0, 1'b0, "R2 flip rc");
    end

    // R4: every stuck position and value, both pass orders
    for (int f = 1; f <= N; f++)
      for (int v = 0; v < 2; v++) begin
        run_pair(1'b0, stuck_obs(1'b0, f, v[0]), stuck_obs(1'b1, f, v[0]), f[0], 1'b0, "R4 stuck");
        chk("R4 stuck located", int'(fidx), f);
        run_pair(1'b1, stuck_obs(1'b1, f, v[0]), stuck_obs(1'b0, f, v[0]), 1'b0, 1'b0, "R4 stuck rev");
      end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule